// File: doc/BRIEF.md
# Indexed Block Register Slave for a Clock Generator

This block is the serial control port of a clock-generator chip. It watches the two SMBus lines and answers at one fixed device address. The address byte 0xDC selects a write and 0xDD selects a read. Behind the port sits a small bank of 8-bit registers. They hold the frequency and spread controls, one enable per output and one stop-enable per output. They also give a live view of the strap pins, a fixed identity byte, a writable device ID and the byte count that a read reports.

A write transfer carries these bytes in order: a start index, a count byte, then data bytes. The data bytes land in successive registers. A read transfer first sets the index with a short write phase. The host then issues a repeated start and the read address. The slave returns the count register first and then register contents from the index upward, for as long as the host acknowledges. Both lines are sampled on the system clock through synchronizers, so the system clock must run at least eight times faster than SCL.

Top module: `idxblk_smb_slave`

## Requirements
- R1: The slave answers only to the 7-bit address 0x6E (address byte bit 0 = 1 for read). For any other address it leaves the acknowledge bit high and ignores the bus until the next start condition.
- R2: The slave acknowledges every byte it receives in an addressed write phase (address, index, count, data) by pulling SDA low during the ninth clock. It only begins to drive SDA while SCL is low.
- R3: In a write, the byte after the address is the start index and the next byte is a count that is not stored. Each following data byte is written to the current index, and the index then advances by one. Registers change only through such data bytes.
- R4: In a read, the first byte returned is the value of register 6 (byte count). Registers from the current index follow, in ascending order, while the host acknowledges. After a host NACK the slave releases SDA until the next start or stop. The host decides how many bytes it reads.
- R5: After reset: register 0 = {strap_i[4:0], 3'b000}, register 1 = 0x0F, register 2 = 0x00, register 5 = 0x08, register 6 = 0x07.
- R6: Register 0 bits 2..0 are always writable. Bits 7..3 take the written value only when bit 2 was already 1 before the write.
- R7: Register 3 is read-only and reads {strap_i[4:0], 3'b000} from the live pins, whatever the setting of register 0 bit 2.
- R8: Register 4 is read-only and reads {REV_ID, 4'b0001}. Register 5 (device ID) is readable and writable.
- R9: Writes to registers 3, 4 and to any index of 7 or above are acknowledged and have no effect. Reads of index 7 or above return 0x00.
- R10: A stop condition releases SDA and ends the transfer. Registers keep their values across it.
- R11: The index persists across stop and repeated start. A read with no index phase continues from where the previous transfer left the index.
- R12: Register 1 bits 3..0 drive out_en_o[3:0]. Register 2 bits 3..0 drive stop_en_o[3:0]. Register 0 drives ctrl_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| strap_i | input | 5 | Live strap levels: [4] input-frequency select, [3:1] frequency select, [0] spread on |
| ctrl_o | output | 8 | Register 0: [7:3] strap-derived controls, [2] software select, [1] stop drive mode, [0] spread type |
| out_en_o | output | NUM_OUT | Per-output enables (register 1) |
| stop_en_o | output | NUM_OUT | Per-output stop enables (register 2) |

## Verification
Random indexed block writes of one to four bytes at indexes 0 to 9 are each followed by a read back at the same index. This shows whether index auto-increment, the read-only and unimplemented holes, and the leading count byte line up with a register model. Directed transfers cover the rest. A foreign address tells a proper NACK-and-ignore apart from a write that leaks through. Register 0 is written before and after software select is set, which separates the lock rule from plain storage. A strap change confirms that register 3 tracks the pins while register 0 does not. A read with no index phase and a stop in the middle of a write separate index persistence from index reset.

// File: rtl/idxblk_pkg.sv
package idxblk_pkg;

    localparam logic [6:0] SLV_ADDR   = 7'h6E;

    localparam logic [7:0] IDX_CTRL   = 8'd0;
    localparam logic [7:0] IDX_OEN    = 8'd1;
    localparam logic [7:0] IDX_STOPEN = 8'd2;
    localparam logic [7:0] IDX_STRAP  = 8'd3;
    localparam logic [7:0] IDX_IDENT  = 8'd4;
    localparam logic [7:0] IDX_DEVID  = 8'd5;
    localparam logic [7:0] IDX_BCNT   = 8'd6;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_RX_FULL, ST_ACK,
        ST_TX, ST_TX_ACK, ST_TX_NEXT, ST_IGNORE
    } bus_state_e;

    typedef enum logic [1:0] {K_ADDR, K_INDEX, K_COUNT, K_DATA} rx_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
    } line_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] idx;
        logic [7:0] data;
    } reg_wr_t;

    function automatic logic addr_hit(input logic [7:0] b);
        return b[7:1] == SLV_ADDR;
    endfunction

    function automatic rx_kind_e kind_after(input rx_kind_e k);
        case (k)
            K_ADDR:  return K_INDEX;
            K_INDEX: return K_COUNT;
            default: return K_DATA;
        endcase
    endfunction

endpackage

// File: rtl/idxblk_line_sync.sv
module idxblk_line_sync
    import idxblk_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw;
    logic [LINES-1:0] synced;
    logic             scl_q;
    logic             sda_q;

    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= synced[1];
            sda_q <= synced[0];
        end
    end

    always_comb begin
        ev.scl      = synced[1];
        ev.sda      = synced[0];
        ev.start    = scl_q && synced[1] && sda_q && !synced[0];
        ev.stop     = scl_q && synced[1] && !sda_q && synced[0];
        ev.scl_rise = !scl_q && synced[1];
        ev.scl_fall = scl_q && !synced[1];
    end
endmodule

// File: rtl/idxblk_bus_fsm.sv
module idxblk_bus_fsm
    import idxblk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  line_ev_t   ev,
    input  logic [7:0] rd_data,
    input  logic [7:0] bcnt,
    output logic [7:0] rd_idx,
    output reg_wr_t    wr,
    output logic       sda_oe
);
    bus_state_e state;
    rx_kind_e   kind;
    logic [2:0] bitcnt;
    logic [7:0] shreg;
    logic       rw;
    logic [7:0] idx;

    assign rd_idx = idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            kind   <= K_ADDR;
            bitcnt <= '0;
            shreg  <= '0;
            rw     <= 1'b0;
            idx    <= '0;
            sda_oe <= 1'b0;
            wr     <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                state  <= ST_RX;
                kind   <= K_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: if (ev.scl_rise) begin
                        shreg  <= {shreg[6:0], ev.sda};
                        bitcnt <= bitcnt + 3'd1;
                        if (bitcnt == 3'd7) state <= ST_RX_FULL;
                    end
                    ST_RX_FULL: if (ev.scl_fall) begin
                        state  <= ST_ACK;
                        sda_oe <= 1'b1;
                        case (kind)
                            K_ADDR: begin
                                if (addr_hit(shreg)) rw <= shreg[0];
                                else begin
                                    state  <= ST_IGNORE;
                                    sda_oe <= 1'b0;
                                end
                            end
                            K_INDEX: idx <= shreg;
                            K_DATA: begin
                                wr.en   <= 1'b1;
                                wr.idx  <= idx;
                                wr.data <= shreg;
                                idx     <= idx + 8'd1;
                            end
                            default: ;
                        endcase
                    end
                    ST_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        bitcnt <= '0;
                        if (kind == K_ADDR && rw) begin
                            state  <= ST_TX;
                            shreg  <= bcnt;
                            sda_oe <= ~bcnt[7];
                        end else begin
                            state <= ST_RX;
                            kind  <= kind_after(kind);
                        end
                    end
                    ST_TX: if (ev.scl_fall) begin
                        if (bitcnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_TX_ACK;
                        end else begin
                            bitcnt <= bitcnt + 3'd1;
                            shreg  <= {shreg[6:0], 1'b0};
                            sda_oe <= ~shreg[6];
                        end
                    end
                    ST_TX_ACK: if (ev.scl_rise) begin
                        state <= ev.sda ? ST_IGNORE : ST_TX_NEXT;
                    end
                    ST_TX_NEXT: if (ev.scl_fall) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        idx    <= idx + 8'd1;
                        bitcnt <= '0;
                        state  <= ST_TX;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/idxblk_regfile.sv
module idxblk_regfile
    import idxblk_pkg::*;
#(
    parameter int         NUM_OUT    = 4,
    parameter logic [3:0] REV_ID     = 4'h2,
    parameter logic [7:0] DEV_ID_RST = 8'h08,
    parameter logic [7:0] BCNT_RST   = 8'h07
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [4:0]         strap,
    input  reg_wr_t            wr,
    input  logic [7:0]         rd_idx,
    output logic [7:0]         rd_data,
    output logic [7:0]         bcnt,
    output logic [7:0]         ctrl,
    output logic [NUM_OUT-1:0] out_en,
    output logic [NUM_OUT-1:0] stop_en
);
    localparam logic [3:0] VENDOR_NIB = 4'b0001;

    logic [7:0]         ctrl_q;
    logic [NUM_OUT-1:0] oen_q;
    logic [NUM_OUT-1:0] stp_q;
    logic [7:0]         devid_q;
    logic [7:0]         bcnt_q;
    logic [7:0]         oen_byte;
    logic [7:0]         stp_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= {strap, 3'b000};
            oen_q   <= '1;
            stp_q   <= '0;
            devid_q <= DEV_ID_RST;
            bcnt_q  <= BCNT_RST;
        end else if (wr.en) begin
            case (wr.idx)
                IDX_CTRL: begin
                    ctrl_q[2:0] <= wr.data[2:0];
                    if (ctrl_q[2]) ctrl_q[7:3] <= wr.data[7:3];
                end
                IDX_OEN:    oen_q   <= wr.data[NUM_OUT-1:0];
                IDX_STOPEN: stp_q   <= wr.data[NUM_OUT-1:0];
                IDX_DEVID:  devid_q <= wr.data;
                IDX_BCNT:   bcnt_q  <= wr.data;
                default: ;
            endcase
        end
    end

    always_comb begin
        oen_byte = '0;
        stp_byte = '0;
        oen_byte[NUM_OUT-1:0] = oen_q;
        stp_byte[NUM_OUT-1:0] = stp_q;
        case (rd_idx)
            IDX_CTRL:   rd_data = ctrl_q;
            IDX_OEN:    rd_data = oen_byte;
            IDX_STOPEN: rd_data = stp_byte;
            IDX_STRAP:  rd_data = {strap, 3'b000};
            IDX_IDENT:  rd_data = {REV_ID, VENDOR_NIB};
            IDX_DEVID:  rd_data = devid_q;
            IDX_BCNT:   rd_data = bcnt_q;
            default:    rd_data = 8'h00;
        endcase
    end

    assign bcnt    = bcnt_q;
    assign ctrl    = ctrl_q;
    assign out_en  = oen_q;
    assign stop_en = stp_q;
endmodule

// File: rtl/idxblk_smb_slave.sv
module idxblk_smb_slave
    import idxblk_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         NUM_OUT     = 4,
    parameter logic [3:0] REV_ID      = 4'h2,
    parameter logic [7:0] DEV_ID_RST  = 8'h08,
    parameter logic [7:0] BCNT_RST    = 8'h07
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    input  logic [4:0]         strap_i,
    output logic [7:0]         ctrl_o,
    output logic [NUM_OUT-1:0] out_en_o,
    output logic [NUM_OUT-1:0] stop_en_o
);
    line_ev_t   ev;
    reg_wr_t    wr;
    logic [7:0] rd_idx;
    logic [7:0] rd_data;
    logic [7:0] bcnt;
    logic       line_scl;
    logic       start_det;
    logic       stop_det;
    logic       wr_strobe;

    idxblk_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    idxblk_bus_fsm u_fsm (
        .clk(clk), .rst(rst), .ev(ev), .rd_data(rd_data), .bcnt(bcnt),
        .rd_idx(rd_idx), .wr(wr), .sda_oe(sda_oe)
    );

    idxblk_regfile #(
        .NUM_OUT(NUM_OUT), .REV_ID(REV_ID),
        .DEV_ID_RST(DEV_ID_RST), .BCNT_RST(BCNT_RST)
    ) u_regs (
        .clk(clk), .rst(rst), .strap(strap_i), .wr(wr), .rd_idx(rd_idx),
        .rd_data(rd_data), .bcnt(bcnt), .ctrl(ctrl_o),
        .out_en(out_en_o), .stop_en(stop_en_o)
    );

    assign line_scl  = ev.scl;
    assign start_det = ev.start;
    assign stop_det  = ev.stop;
    assign wr_strobe = wr.en;
endmodule

// File: rtl/idxblk_smb_checker.sv
module idxblk_smb_checker #(
    parameter int NUM_OUT = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               line_scl,
    input logic               start_det,
    input logic               stop_det,
    input logic               wr_strobe,
    input logic               sda_oe,
    input logic [7:0]         ctrl_o,
    input logic [NUM_OUT-1:0] out_en_o,
    input logic [NUM_OUT-1:0] stop_en_o
);
    // SDA drive only begins while the synchronized SCL is low
    assert_drive_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !line_scl);

    // a start condition aborts any drive on the following cycle
    assert_start_release_R1: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);

    // a stop condition frees the line
    assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);

    // strap-derived control bits hold while software select is clear
    assert_ctrl_locked_R6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_o[2] |=> $stable(ctrl_o[7:3]));

    // output registers only move on a data-byte write strobe
    assert_oen_write_only_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe |=> $stable(out_en_o));

    assert_stop_en_write_only_R12: assert property (@(posedge clk) disable iff (rst)
        !wr_strobe |=> $stable(stop_en_o));
endmodule

bind idxblk_smb_slave idxblk_smb_checker #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk(clk), .rst(rst), .line_scl(line_scl), .start_det(start_det),
    .stop_det(stop_det), .wr_strobe(wr_strobe), .sda_oe(sda_oe),
    .ctrl_o(ctrl_o), .out_en_o(out_en_o), .stop_en_o(stop_en_o)
);

// File: tb/idxblk_smb_slave_bench.sv
`timescale 1ns/1ps
module idxblk_smb_slave_bench;
    localparam int HQ = 6;
    localparam logic [7:0] REV_BYTE = 8'h21;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       host_low = 1'b0;
    logic       sda_line;
    logic       sda_oe;
    logic [4:0] strap = 5'b10110;
    logic [7:0] ctrl_o;
    logic [3:0] out_en_o;
    logic [3:0] stop_en_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] m_ctrl, m_oen, m_stp, m_dev, m_bcnt, m_idx;
    logic [7:0] wbuf [8];

    always #2.5 clk = ~clk;
    assign sda_line = !(host_low || sda_oe);

    idxblk_smb_slave u_idxblk_smb_slave (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap_i(strap), .ctrl_o(ctrl_o), .out_en_o(out_en_o), .stop_en_o(stop_en_o)
    );

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [7:0] i);
        case (i)
            8'd0: return m_ctrl;
            8'd1: return m_oen;
            8'd2: return m_stp;
            8'd3: return {strap, 3'b000};
            8'd4: return REV_BYTE;
            8'd5: return m_dev;
            8'd6: return m_bcnt;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_wr(input logic [7:0] i, input logic [7:0] d);
        case (i)
            8'd0: begin
                if (m_ctrl[2]) m_ctrl[7:3] = d[7:3];
                m_ctrl[2:0] = d[2:0];
            end
            8'd1: m_oen = {4'b0, d[3:0]};
            8'd2: m_stp = {4'b0, d[3:0]};
            8'd5: m_dev = d;
            8'd6: m_bcnt = d;
            default: ;
        endcase
    endtask

    task automatic bus_start();
        host_low = 1'b1; tk(HQ); scl = 1'b0; tk(HQ);
    endtask

    task automatic bus_rstart();
        host_low = 1'b0; tk(HQ); scl = 1'b1; tk(HQ);
        host_low = 1'b1; tk(HQ); scl = 1'b0; tk(HQ);
    endtask

    task automatic bus_stop();
        host_low = 1'b1; tk(HQ); scl = 1'b1; tk(HQ);
        host_low = 1'b0; tk(2*HQ);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            host_low = !b[i]; tk(HQ); scl = 1'b1; tk(2*HQ); scl = 1'b0; tk(HQ);
        end
        host_low = 1'b0; tk(HQ); scl = 1'b1; tk(HQ);
        ack = !sda_line;
        tk(HQ); scl = 1'b0; tk(HQ);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic ack_it);
        host_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tk(HQ); scl = 1'b1; tk(HQ); b[i] = sda_line; tk(HQ); scl = 1'b0; tk(HQ);
        end
        host_low = ack_it; tk(HQ); scl = 1'b1; tk(2*HQ); scl = 1'b0; tk(HQ);
        host_low = 1'b0;
    endtask

    task automatic blk_write(input logic [7:0] idx, input int n, input string req);
        logic a;
        bus_start();
        send_byte(8'hDC, a); chk({req, " R2 addr ack"}, a, 1);
        send_byte(idx, a);   chk({req, " R2 index ack"}, a, 1);
        send_byte(n[7:0], a); chk({req, " R3 count ack"}, a, 1);
        for (int k = 0; k < n; k++) begin
            send_byte(wbuf[k], a); chk({req, " R2 data ack"}, a, 1);
            model_wr(idx + k[7:0], wbuf[k]);
        end
        bus_stop();
        m_idx = idx + n[7:0];
        chk({req, " R12 ctrl"}, ctrl_o, m_ctrl);
        chk({req, " R12 out_en"}, out_en_o, m_oen[3:0]);
        chk({req, " R12 stop_en"}, stop_en_o, m_stp[3:0]);
    endtask

    task automatic blk_read(input logic set_idx, input logic [7:0] idx, input int n, input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        if (set_idx) begin
            send_byte(8'hDC, a); chk({req, " R2 addr ack"}, a, 1);
            send_byte(idx, a);   chk({req, " R2 index ack"}, a, 1);
            bus_rstart();
            m_idx = idx;
        end
        send_byte(8'hDD, a); chk({req, " R1 read addr ack"}, a, 1);
        recv_byte(b, 1'b1); chk({req, " R4 count byte"}, b, m_bcnt);
        for (int k = 0; k < n; k++) begin
            recv_byte(b, k != n-1);
            chk({req, " R4 data"}, b, exp_rd(m_idx + k[7:0]));
        end
        bus_stop();
        chk({req, " R4 released"}, sda_oe, 0);
        m_idx = m_idx + n[7:0];
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a;
        void'($urandom(32'h5EED_1234));
        m_ctrl = {strap, 3'b000}; m_oen = 8'h0F; m_stp = 8'h00;
        m_dev = 8'h08; m_bcnt = 8'h07; m_idx = 8'h00;
        tk(10); rst = 1'b0; tk(10);

        // R5 reset values at the ports
        chk("R5 ctrl reset", ctrl_o, {5'b10110, 3'b000});
        chk("R5 out_en reset", out_en_o, 4'hF);
        chk("R5 stop_en reset", stop_en_o, 4'h0);
        chk("R5 sda idle", sda_oe, 0);

        // R5 R7 R8 full read of the bank
        blk_read(1'b1, 8'd0, 7, "R5 R7 R8 full bank");

        // R1 foreign address: NACK, rest ignored
        bus_start();
        send_byte(8'hA0, a); chk("R1 foreign addr nack", a, 0);
        send_byte(8'h01, a); chk("R1 ignored byte nack", a, 0);
        send_byte(8'h01, a); send_byte(8'h00, a);
        bus_stop();
        chk("R1 out_en untouched", out_en_o, 4'hF);

        // R6 top bits locked while software select is clear
        wbuf[0] = 8'h07; blk_write(8'd0, 1, "R6 locked");
        chk("R6 top bits held", ctrl_o[7:3], 5'b10110);
        wbuf[0] = 8'h4D; blk_write(8'd0, 1, "R6 unlocked");
        chk("R6 top bits written", ctrl_o, 8'h4D);

        // R7 live strap view; register 0 unaffected
        strap = 5'b01001; tk(10);
        blk_read(1'b1, 8'd3, 1, "R7 strap live");
        chk("R7 ctrl kept", ctrl_o, 8'h4D);

        // R8 R9 read-only and unimplemented writes ignored
        wbuf[0] = 8'hAA; wbuf[1] = 8'h55; blk_write(8'd3, 2, "R9 ro write");
        wbuf[0] = 8'h33; wbuf[1] = 8'h44; blk_write(8'd7, 2, "R9 hole write");
        blk_read(1'b1, 8'd3, 3, "R8 ident and devid");
        blk_read(1'b1, 8'd7, 3, "R9 holes read zero");

        // R4 count register value leads a read
        wbuf[0] = 8'h03; blk_write(8'd6, 1, "R4 set count");
        blk_read(1'b1, 8'd5, 2, "R4 new count");

        // R11 index persists; read without index phase
        wbuf[0] = 8'h05; wbuf[1] = 8'h02; blk_write(8'd1, 2, "R11 setup");
        blk_read(1'b0, 8'd0, 3, "R11 continue");

        // R10 stop in the middle of a write
        bus_start();
        send_byte(8'hDC, a); send_byte(8'h01, a);
        bus_stop();
        chk("R10 released", sda_oe, 0);
        chk("R10 out_en kept", out_en_o, m_oen[3:0]);
        m_idx = 8'h01;
        blk_read(1'b0, 8'd0, 1, "R10 R11 index after stop");

        // random block writes with readback
        for (int it = 0; it < 20; it++) begin
            int n;
            logic [7:0] idx;
            idx = 8'($urandom_range(0, 9));
            n = $urandom_range(1, 4);
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            if (it % 5 == 0) strap = 5'($urandom);
            blk_write(idx, n, "R3 random write");
            blk_read(1'b1, idx, n, "R3 random readback");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule